// File: doc/BRIEF.md
# Encoder Input Glitch Filter

This block cleans up the three raw encoder lines (two quadrature phases and the index line) before they reach the decoder. Each line first goes through a two-flop synchroniser. One configuration is shared by all three lines. It holds a filter-on bit and a 21-bit length value `L`.

With the filter off, each synchronised line goes straight to the output. With the filter on, an output moves to a new level only after the synchronised line has held that level for more than `L + 2` clock periods. A shorter disturbance leaves the output where it was. At a 10 ns clock the shortest enabled window is therefore 20 ns.

The configuration is loaded from a write strobe, and only while the peripheral enable is low. The three lines are filtered by separate, identical channels. After reset each output is loaded directly from its synchronised input, so it does not first have to pass the filter window.

Top module: `glitch_filter`

## Requirements
- R1: While rst_ni is low, every bit of filt_o is 0.
- R2: After rst_ni rises, filt_o equals the level held on raw_i from the third rising clock edge onward, whatever the filter setting and length. With the reset defaults (filter on, length 4), the output needs no filter wait.
- R3: With the filter off (cfg_flt_en_i = 0 loaded), filt_o[c] equals raw_i[c] as sampled two rising edges earlier, for any pulse width.
- R4: With the filter on and length L, a new level that raw_i[c] holds for P consecutive sampling edges reaches filt_o[c] only if P >= L + 3. A pulse with P <= L + 2 leaves filt_o[c] unchanged. This applies to high-going and low-going pulses alike.
- R5: An accepted level change appears on filt_o[c] right after the (L + 5)th rising edge, counting the first edge that samples the new raw level as edge 1. The return to the old level is delayed by the same amount.
- R6: A config write (cfg_we_i = 1) loads cfg_flt_en_i and cfg_len_i at the rising edge only when enable_i is 0. When enable_i is 1 the write is ignored and the previous filter behaviour stays in force.
- R7: All channels use the same length and filter-on bit. Each channel keeps its own stable-time counter, so pulses of different widths on different lines are accepted or rejected independently in the same cycles.
- R8: The stable-time counter of a channel never exceeds L + 2, including for L = 0x1FFFFF, and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Filter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Peripheral enable; while high, config writes are ignored |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_flt_en_i | input | 1 | Filter-on value to load (0 = bypass) |
| cfg_len_i | input | CW | Length value L to load; window is L + 2 clocks |
| raw_i | input | NCH | Asynchronous encoder lines (bit 0 phase A, bit 1 phase B, bit 2 index) |
| filt_o | output | NCH | Filtered lines toward the decoder |

## Verification
The bench builds the block with its default three channels and the full 21-bit length field, and programs lengths 0, 1, 2 and 5. These short lengths make every pulse width from one clock up to just past the accept boundary cheap to sweep, on every channel and in both polarities. The expected output of each cycle is derived from the L + 3 acceptance rule and the L + 5 edge latency. The counter bound at the widest length is left to the bound checker, because a sweep at that length would take millions of cycles.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int unsigned GF_NCH_DEF = 3;
  localparam int unsigned GF_CW_DEF  = 21;
  localparam int unsigned GF_PRIME_CYC = 3;   // edges of direct load after reset
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gf_cfg.sv
module gf_cfg #(
  parameter int unsigned CW         = 21,
  parameter logic        RST_FLT_EN = 1'b1,
  parameter int unsigned RST_LEN    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          we_i,
  input  logic          flt_en_i,
  input  logic [CW-1:0] len_i,
  output logic          flt_en_o,
  output logic [CW-1:0] len_o
);
  logic          flt_en_q;
  logic [CW-1:0] len_q;

  // config is frozen while the peripheral runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_en_q <= RST_FLT_EN;
      len_q    <= CW'(RST_LEN);
    end else if (we_i && !enable_i) begin
      flt_en_q <= flt_en_i;
      len_q    <= len_i;
    end
  end

  assign flt_en_o = flt_en_q;
  assign len_o    = len_q;
endmodule

// File: rtl/gf_chan.sv
module gf_chan #(
  parameter int unsigned CW = 21,
  localparam int unsigned WW = CW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prime_i,
  input  logic          flt_en_i,
  input  logic [WW-1:0] win_i,
  input  logic          sync_i,
  output logic          filt_o,
  output logic [WW-1:0] cnt_o
);
  logic          filt_q;
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (prime_i || !flt_en_i) begin
      // track input so a later switch to filtering starts clean
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else if (sync_i == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_q >= win_i) begin
      // >= lets a counter left over from a longer window recover
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + WW'(1);
    end
  end

  assign filt_o = filt_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int unsigned NCH        = gf_pkg::GF_NCH_DEF,
  parameter int unsigned CW         = gf_pkg::GF_CW_DEF,
  parameter logic        RST_FLT_EN = 1'b1,
  parameter int unsigned RST_LEN    = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           enable_i,
  input  logic           cfg_we_i,
  input  logic           cfg_flt_en_i,
  input  logic [CW-1:0]  cfg_len_i,
  input  logic [NCH-1:0] raw_i,
  output logic [NCH-1:0] filt_o
);
  localparam int unsigned WW = CW + 2;
  localparam int unsigned PW = $clog2(gf_pkg::GF_PRIME_CYC + 1);

  logic [NCH-1:0]         sync_q;
  logic                   flt_en_q;
  logic [CW-1:0]          len_q;
  logic [WW-1:0]          win;
  logic [PW-1:0]          prime_cnt_q;
  logic                   prime;
  logic [NCH-1:0]         chan_filt;
  logic [NCH-1:0][WW-1:0] cnt_q;

  gf_sync #(.W(NCH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_q)
  );

  gf_cfg #(.CW(CW), .RST_FLT_EN(RST_FLT_EN), .RST_LEN(RST_LEN)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .we_i    (cfg_we_i),
    .flt_en_i(cfg_flt_en_i),
    .len_i   (cfg_len_i),
    .flt_en_o(flt_en_q),
    .len_o   (len_q)
  );

  assign win = WW'(len_q) + WW'(2);

  // outputs load directly until the synchroniser holds real input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       prime_cnt_q <= '0;
    else if (prime_cnt_q != PW'(gf_pkg::GF_PRIME_CYC)) prime_cnt_q <= prime_cnt_q + PW'(1);
  end
  assign prime = (prime_cnt_q != PW'(gf_pkg::GF_PRIME_CYC));

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    gf_chan #(.CW(CW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .prime_i (prime),
      .flt_en_i(flt_en_q),
      .win_i   (win),
      .sync_i  (sync_q[c]),
      .filt_o  (chan_filt[c]),
      .cnt_o   (cnt_q[c])
    );
    assign filt_o[c] = flt_en_q ? chan_filt[c] : sync_q[c];
  end
endmodule

// File: rtl/glitch_filter_chk.sv
module glitch_filter_chk #(
  parameter int unsigned NCH = 3,
  parameter int unsigned CW  = 21,
  localparam int unsigned WW = CW + 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   enable_i,
  input logic [NCH-1:0]         raw_i,
  input logic [NCH-1:0]         filt_o,
  input logic [NCH-1:0]         sync_q,
  input logic                   flt_en_q,
  input logic [CW-1:0]          len_q,
  input logic [NCH-1:0][WW-1:0] cnt_q
);
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
  end

  always_comb begin
    if (!rst_ni) AST_RESET_LOW: assert (filt_o == '0); // R1
  end

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> ($stable(len_q) && $stable(flt_en_q))); // R6

  AST_BYPASS_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd3 && !flt_en_q) |-> (filt_o == $past(raw_i, 2))); // R3

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_HOLD_BEFORE_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 3'd5 && flt_en_q && $past(flt_en_q) && filt_o[c] != $past(filt_o[c]))
      |-> ($past(sync_q[c]) == filt_o[c] && $past(sync_q[c], 2) == filt_o[c])); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (len_q == $past(len_q)) |-> (cnt_q[c] <= WW'(len_q) + WW'(2))); // R8
  end
endmodule

bind glitch_filter glitch_filter_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .enable_i(enable_i),
  .raw_i   (raw_i),
  .filt_o  (filt_o),
  .sync_q  (sync_q),
  .flt_en_q(flt_en_q),
  .len_q   (len_q),
  .cnt_q   (cnt_q)
);

// File: tb/glitch_filter_tb.sv
module glitch_filter_tb;
  localparam int NCH = 3;
  localparam int CW  = 21;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           enable_i = 1'b0;
  logic           cfg_we_i = 1'b0;
  logic           cfg_flt_en_i = 1'b0;
  logic [CW-1:0]  cfg_len_i = '0;
  logic [NCH-1:0] raw_i = '0;
  logic [NCH-1:0] filt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  glitch_filter u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_flt_en_i(cfg_flt_en_i),
    .cfg_len_i   (cfg_len_i),
    .raw_i       (raw_i),
    .filt_o      (filt_o)
  );

  task automatic check(logic [NCH-1:0] exp, string req);
    n_chk++;
    if (filt_o !== exp) begin
      n_bad++;
      $display("FAIL %s: filt_o=%b expected %b at %0t", req, filt_o, exp, $time);
    end
  endtask

  task automatic write_cfg(bit en, int len);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_flt_en_i = en; cfg_len_i = CW'(len);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // expected level of one channel after edge k (edge 1 samples the new level)
  function automatic bit hit(int w, int k, int len, bit byp);
    if (w == 0) return 1'b0;
    if (byp)    return (k >= 2) && (k < w + 2);
    return (w >= len + 3) && (k >= len + 5) && (k < w + len + 5);
  endfunction

  // pulses of widths w0..w2 (0 = none) start together on the three lines
  task automatic run(int w0, int w1, int w2, bit pol, int len, bit byp, string req);
    int w[3];
    int last;
    logic [NCH-1:0] base, exp;
    w[0] = w0; w[1] = w1; w[2] = w2;
    base = pol ? '0 : '1;
    raw_i = base;
    repeat (len + 12) @(negedge clk_i);
    last = 0;
    for (int c = 0; c < NCH; c++) if (w[c] > last) last = w[c];
    for (int k = 0; k <= last + len + 8; k++) begin
      @(negedge clk_i);
      if (k > 0) begin
        for (int c = 0; c < NCH; c++) exp[c] = hit(w[c], k, len, byp) ? pol : ~pol;
        check(exp, req);
      end
      for (int c = 0; c < NCH; c++) raw_i[c] = (k < w[c]) ? pol : ~pol;
    end
  endtask

  initial begin
    int lens[4];
    lens[0] = 0; lens[1] = 1; lens[2] = 2; lens[3] = 5;

    // R1: outputs low in reset, R2: direct load after release
    raw_i = 3'b101;
    repeat (3) @(negedge clk_i);
    check(3'b000, "R1");
    rst_ni = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk_i);
      if (k >= 3) check(3'b101, "R2");
    end

    // R4/R5: width sweep around the accept boundary, every line, both polarities
    foreach (lens[i]) begin
      write_cfg(1'b1, lens[i]);
      for (int c = 0; c < NCH; c++)
        for (int pol = 0; pol < 2; pol++)
          for (int p = 1; p <= lens[i] + 4; p++)
            run(c == 0 ? p : 0, c == 1 ? p : 0, c == 2 ? p : 0, pol[0], lens[i], 1'b0,
                (p >= lens[i] + 3) ? "R5" : "R4");
    end

    // R7: concurrent pulses, one rejected between two accepted
    write_cfg(1'b1, 2);
    run(5, 4, 6, 1'b1, 2, 1'b0, "R7");
    run(4, 6, 5, 1'b0, 2, 1'b0, "R7");

    // R3: bypass
    write_cfg(1'b0, 3);
    for (int p = 1; p <= 3; p++) begin
      run(p, 0, p + 1, 1'b1, 0, 1'b1, "R3");
      run(0, p, 0, 1'b0, 0, 1'b1, "R3");
    end

    // R6: write while enabled is ignored, filter with L=3 stays
    write_cfg(1'b1, 3);
    enable_i = 1'b1;
    write_cfg(1'b0, 0);
    run(1, 5, 6, 1'b1, 3, 1'b0, "R6");
    enable_i = 1'b0;
    write_cfg(1'b0, 0);
    run(1, 0, 2, 1'b1, 0, 1'b1, "R6");

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule